// File: doc/BRIEF.md
# Eight-Level Multi-Mode Priority Interrupt Controller

This block collects interrupt requests from eight sources, holds each one until it is acknowledged, and picks one winning level to present to a processor. Software writes a small register port to set the priority scheme, the per-level mask, the level that currently ranks last, and the base of the vector table. Software also writes it to end the service of a level. There are four schemes: fixed nesting, rotation after service, a software-named lowest level, and polling. Software may switch between them at any time.

When the interrupt output is high, the vector output gives the address of the winning level's table entry. Entries are four bytes apart inside a 32-byte table, which can sit on any 32-byte boundary below 1 KB. Pulsing the acknowledge input moves the winner from pending to in-service. In polled mode the interrupt output stays low. Software instead reads a status byte that encodes the highest pending level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset the scheme is fixed nesting, the mask is clear, the last-ranked level is 7, the table base is 0, nothing is pending or in service, and `int_out` is low.
- R2: A request high for one cycle on `irq_in[n]` stays pending until it is acknowledged. `int_out` rises in the cycle after the request is sampled. Pending state reads back at register address 6 (bit n = level n).
- R3: Mask register address 1 (bit n = level n) stops a masked pending level from driving `int_out`. The request stays pending and is presented once the mask bit is cleared.
- R4: In fixed nesting (mode value 0 at register address 0), level 0 ranks highest and level 7 lowest.
- R5: In every mode except polled, a pending level raises `int_out` only if it ranks above every in-service level. Lower-ranked requests wait until end-of-service.
- R6: An `int_ack` pulse while `int_out` is high marks the presented level in service (register address 3 reads in-service bits) and clears its pending bit. An `int_ack` while `int_out` is low changes nothing.
- R7: A write to register address 3 with the level in bits 2:0 ends that level's service.
- R8: In rotating mode (mode value 1), ending service of level v makes v the lowest-ranked level. The ranking then runs v+1, v+2, … wrapping through v.
- R9: In specific mode (mode value 2), register address 2 bits 2:0 name the lowest-ranked level L. The ranking runs L+1, L+2, … wrapping through L.
- R10: In polled mode (mode value 3), `int_out` stays low. Register address 5 reads bit 7 set when any unmasked request is pending and bits 2:0 holding the highest such level in fixed order. All other bits read 0, and the byte is 0x00 when nothing is pending.
- R11: `vec_addr` is {table base, level, 2'b00}. The 5-bit table base is written at register address 4, bits 4:0.
- R12: A mode write takes effect for the arbitration in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request inputs, one per level |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `reg_addr` (combinational) |
| int_out | output | 1 | Interrupt to processor |
| int_ack | input | 1 | Acknowledge of the presented level |
| vec_addr | output | 10 | Table address of the presented level |

## Verification
All state sits in one register stage. `int_out`, `vec_addr` and the read data are combinational from that state. A request, mask or mode write, acknowledge or end-of-service therefore shows its effect one clock edge after it is driven. The bench drives every input on the falling edge and holds it across exactly one rising edge. It then samples outputs at the following falling edge, which is one cycle after the stimulus. For a result that must not appear, such as a blocked lower level or an ignored acknowledge, the bench reads the pending and in-service registers back at that same point.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LVLS   = 8;
    localparam int LVL_W  = $clog2(LVLS);
    localparam int BASE_W = 5;
    localparam int VEC_W  = BASE_W + LVL_W + 2;

    typedef enum logic [1:0] {
        PRI_NESTED   = 2'd0,
        PRI_ROTATE   = 2'd1,
        PRI_SPECIFIC = 2'd2,
        PRI_POLLED   = 2'd3
    } pri_mode_e;

    typedef enum logic [2:0] {
        RA_MODE   = 3'd0,
        RA_MASK   = 3'd1,
        RA_LOWEST = 3'd2,
        RA_EOS    = 3'd3,
        RA_BASE   = 3'd4,
        RA_POLL   = 3'd5,
        RA_PEND   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic             found;
        logic [LVL_W-1:0] rank;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    function automatic logic [LVLS-1:0] lvl_bit(input logic [LVL_W-1:0] l);
        return LVLS'(1) << l;
    endfunction
endpackage

// File: rtl/pic_pick.sv
module pic_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] lowest,
    output logic         found,
    output logic [W-1:0] rank,
    output logic [W-1:0] lvl
);
    logic [N-1:0] rot;

    for (genvar k = 0; k < N; k++) begin : g_rot
        assign rot[k] = vec[W'(lowest + W'(k + 1))];
    end

    always_comb begin
        found = 1'b0;
        rank  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) begin
                found = 1'b1;
                rank  = W'(k);
            end
        end
    end

    assign lvl = lowest + rank + W'(1);
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [LVLS-1:0]     irq_in,
    input  logic                wr_en,
    input  logic [2:0]          reg_addr,
    input  logic [7:0]          wr_data,
    input  logic                take,
    input  logic [LVL_W-1:0]    take_lvl,
    output pri_mode_e           mode_q,
    output logic [LVLS-1:0]     mask_q,
    output logic [LVL_W-1:0]    lowest_q,
    output logic [BASE_W-1:0]   base_q,
    output logic [LVLS-1:0]     irr_q,
    output logic [LVLS-1:0]     isr_q
);
    logic [LVLS-1:0]  irr_n, isr_n;
    logic [LVL_W-1:0] lowest_n;
    logic             eos_wr;
    logic [LVL_W-1:0] wr_lvl;

    assign eos_wr = wr_en && (reg_addr == RA_EOS);
    assign wr_lvl = wr_data[LVL_W-1:0];

    always_comb begin
        irr_n = (irr_q & ~(take ? lvl_bit(take_lvl) : '0)) | irq_in;
        isr_n = isr_q;
        if (take)   isr_n = isr_n | lvl_bit(take_lvl);
        if (eos_wr) isr_n = isr_n & ~lvl_bit(wr_lvl);
        lowest_n = lowest_q;
        if (wr_en && reg_addr == RA_LOWEST)        lowest_n = wr_lvl;
        if (eos_wr && mode_q == PRI_ROTATE)        lowest_n = wr_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= PRI_NESTED;
            mask_q   <= '0;
            lowest_q <= '1;
            base_q   <= '0;
            irr_q    <= '0;
            isr_q    <= '0;
        end else begin
            irr_q    <= irr_n;
            isr_q    <= isr_n;
            lowest_q <= lowest_n;
            if (wr_en && reg_addr == RA_MODE) mode_q <= pri_mode_e'(wr_data[1:0]);
            if (wr_en && reg_addr == RA_MASK) mask_q <= wr_data[LVLS-1:0];
            if (wr_en && reg_addr == RA_BASE) base_q <= wr_data[BASE_W-1:0];
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         irq_in,
    input  logic               wr_en,
    input  logic [2:0]         reg_addr,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    output logic               int_out,
    input  logic               int_ack,
    output logic [9:0]         vec_addr
);
    pri_mode_e          mode_q;
    logic [LVLS-1:0]    mask_q, irr_q, isr_q, req_v;
    logic [LVL_W-1:0]   lowest_q, eff_lowest;
    logic [BASE_W-1:0]  base_q;
    pick_t              req_p, srv_p;
    logic               grant_ok, take;
    logic [7:0]         poll_byte;

    pic_regs u_regs (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
        .take(take), .take_lvl(req_p.lvl),
        .mode_q(mode_q), .mask_q(mask_q), .lowest_q(lowest_q),
        .base_q(base_q), .irr_q(irr_q), .isr_q(isr_q)
    );

    assign eff_lowest = (mode_q == PRI_ROTATE || mode_q == PRI_SPECIFIC) ? lowest_q : '1;
    assign req_v      = irr_q & ~mask_q;

    pic_pick #(.N(LVLS), .W(LVL_W)) u_req_pick (
        .vec(req_v), .lowest(eff_lowest),
        .found(req_p.found), .rank(req_p.rank), .lvl(req_p.lvl)
    );

    pic_pick #(.N(LVLS), .W(LVL_W)) u_srv_pick (
        .vec(isr_q), .lowest(eff_lowest),
        .found(srv_p.found), .rank(srv_p.rank), .lvl(srv_p.lvl)
    );

    assign grant_ok = req_p.found && (!srv_p.found || req_p.rank < srv_p.rank);
    assign int_out  = grant_ok && (mode_q != PRI_POLLED);
    assign take     = int_ack && int_out;
    assign vec_addr = {base_q, req_p.lvl, 2'b00};

    always_comb begin
        poll_byte = '0;
        if (req_p.found) begin
            poll_byte[7]         = 1'b1;
            poll_byte[LVL_W-1:0] = req_p.lvl;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_MODE:   rd_data = {6'b0, mode_q};
            RA_MASK:   rd_data = mask_q;
            RA_LOWEST: rd_data = 8'(lowest_q);
            RA_EOS:    rd_data = isr_q;
            RA_BASE:   rd_data = 8'(base_q);
            RA_POLL:   rd_data = poll_byte;
            RA_PEND:   rd_data = irr_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pic_chk.sv
module pic_chk
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              int_out,
    input  logic              int_ack,
    input  logic [VEC_W-1:0]  vec_addr,
    input  pri_mode_e         mode_q,
    input  logic [LVLS-1:0]   mask_q,
    input  logic [LVLS-1:0]   irr_q,
    input  logic [LVLS-1:0]   isr_q
);
    logic [LVL_W-1:0] pres_lvl;
    logic [LVLS-1:0]  at_or_above;

    assign pres_lvl = vec_addr[LVL_W+1:2];

    always_comb begin
        for (int i = 0; i < LVLS; i++) at_or_above[i] = (LVL_W'(i) <= pres_lvl);
    end

    assert_polled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        mode_q == PRI_POLLED |-> !int_out);

    assert_unmasked_pending_R3: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (!mask_q[pres_lvl] && irr_q[pres_lvl]));

    assert_pending_held_R2: assert property (@(posedge clk) disable iff (rst)
        !(int_ack && int_out) |=> (($past(irr_q) & ~irr_q) == '0));

    assert_ack_sets_service_R6: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_out) |=> isr_q[$past(pres_lvl)]);

    assert_nested_block_R5: assert property (@(posedge clk) disable iff (rst)
        (int_out && mode_q == PRI_NESTED) |-> ((isr_q & at_or_above) == '0));
endmodule

bind irq_prio_ctrl pic_chk u_chk (
    .clk(clk), .rst(rst), .int_out(int_out), .int_ack(int_ack),
    .vec_addr(vec_addr), .mode_q(mode_q), .mask_q(mask_q),
    .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       wr_en;
    logic [2:0] reg_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       int_out;
    logic       int_ack;
    logic [9:0] vec_addr;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .int_out(int_out), .int_ack(int_ack), .vec_addr(vec_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = rd_data;
    endtask

    task automatic pulse(input logic [7:0] lv);
        @(negedge clk);
        irq_in = lv;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic ack();
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 int_out", int_out, 0);
        rd(0, d); check("R1 mode", d, 8'h00);
        rd(1, d); check("R1 mask", d, 8'h00);
        rd(2, d); check("R1 lowest", d, 8'h07);
        rd(4, d); check("R1 base", d, 8'h00);
        rd(6, d); check("R1 pending", d, 8'h00);
        rd(3, d); check("R1 in-service", d, 8'h00);
    endtask

    task automatic t_latch_ack();
        logic [7:0] d;
        ack();
        rd(3, d); check("R6 ack ignored when idle", d, 8'h00);
        pulse(8'h10);
        check("R2 int_out after pulse", int_out, 1);
        rd(6, d); check("R2 held pending", d, 8'h10);
        check("R11 vector base 0 lvl 4", vec_addr, 10'h010);
        ack();
        rd(3, d); check("R6 in-service set", d, 8'h10);
        rd(6, d); check("R6 pending cleared", d, 8'h00);
        check("R6 int_out low after ack", int_out, 0);
        wr(3, 8'h04);
        rd(3, d); check("R7 eos clears", d, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(1, 8'h08);
        pulse(8'h08);
        check("R3 masked no int", int_out, 0);
        rd(6, d); check("R3 masked still pending", d, 8'h08);
        wr(1, 8'h00);
        check("R3 unmasked int", int_out, 1);
        check("R3 unmasked vector", vec_addr, 10'h00C);
        ack(); wr(3, 8'h03);
    endtask

    task automatic t_nested();
        logic [7:0] d;
        pulse(8'h24);
        check("R4 level 2 beats 5", vec_addr[4:2], 3'd2);
        ack();
        check("R5 level 5 blocked by 2", int_out, 0);
        pulse(8'h02);
        check("R5 level 1 preempts", int_out, 1);
        check("R4 level 1 presented", vec_addr[4:2], 3'd1);
        ack();
        rd(3, d); check("R6 two in service", d, 8'h06);
        wr(3, 8'h01);
        check("R5 still blocked by 2", int_out, 0);
        wr(3, 8'h02);
        check("R5 released", int_out, 1);
        check("R5 level 5 presented", vec_addr[4:2], 3'd5);
        ack(); wr(3, 8'h05);
        rd(3, d); check("R7 all ended", d, 8'h00);
    endtask

    task automatic t_rotate();
        logic [7:0] d;
        wr(0, 8'h01);
        pulse(8'h44);
        check("R8 initial order level 2", vec_addr[4:2], 3'd2);
        ack(); wr(3, 8'h02);
        rd(2, d); check("R8 lowest becomes 2", d, 8'h02);
        pulse(8'h02);
        check("R8 level 6 beats 1", vec_addr[4:2], 3'd6);
        ack(); wr(3, 8'h06);
        check("R8 level 1 next", vec_addr[4:2], 3'd1);
        ack(); wr(3, 8'h01);
        rd(2, d); check("R8 lowest becomes 1", d, 8'h01);
    endtask

    task automatic t_specific();
        wr(0, 8'h02);
        wr(2, 8'h04);
        pulse(8'h28);
        check("R9 lowest 4: level 5 wins", vec_addr[4:2], 3'd5);
        wr(2, 8'h05);
        check("R9 lowest 5: level 3 wins", vec_addr[4:2], 3'd3);
        ack(); wr(3, 8'h03);
        ack(); wr(3, 8'h05);
        check("R9 drained", int_out, 0);
    endtask

    task automatic t_polled();
        logic [7:0] d;
        wr(0, 8'h03);
        rd(5, d); check("R10 empty poll", d, 8'h00);
        pulse(8'h50);
        check("R10 no int_out", int_out, 0);
        rd(5, d); check("R10 poll 4", d, 8'h84);
        ack();
        rd(6, d); check("R6 ack ignored in polled", d, 8'h50);
        wr(1, 8'h10);
        rd(5, d); check("R10 poll 6 after mask", d, 8'h86);
        wr(1, 8'hFF);
        rd(5, d); check("R10 all masked", d, 8'h00);
        wr(1, 8'h00);
        wr(0, 8'h00);
        check("R12 switch to nested drives int", int_out, 1);
        check("R12 nested picks 4", vec_addr[4:2], 3'd4);
        ack(); wr(3, 8'h04);
        ack(); wr(3, 8'h06);
    endtask

    task automatic t_vector();
        wr(4, 8'h1F);
        pulse(8'h80);
        check("R11 vector base 1F lvl 7", vec_addr, 10'h3FC);
        ack(); wr(3, 8'h07);
        wr(4, 8'h03);
        pulse(8'h01);
        check("R11 vector base 3 lvl 0", vec_addr, 10'h060);
        ack(); wr(3, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; irq_in = '0; wr_en = 1'b0; reg_addr = '0;
        wr_data = '0; int_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch_ack();
        t_mask();
        t_nested();
        t_rotate();
        t_specific();
        t_polled();
        t_vector();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule